// File: doc/BRIEF.md
# Timer Counter with Event Flags and Selectable Flag Clearing

This block is a free-running up-counter driven through a prescaler, together with a bank of per-channel event flags and a counter-wrap flag. Software reaches it over a small register bus made of read and write strobes, an address and write data. Read data comes back combinationally for the presented address. Each channel also owns a data register that software uses as its capture or compare value. A one-cycle event pulse from a channel raises that channel's flag.

A control bit picks how flags are cleared. In the normal method, writing a one to a flag bit clears it. In fast-clear mode that method is switched off. Instead, any read or write of a channel's data register clears that channel's flag, and any read or write of the counter register clears the wrap flag. A second control bit picks the prescaler: a legacy power-of-two divider chosen by a 3-bit field, or a precision divider set by a full 8-bit register. A freeze input halts the counter and prescaler, but only when the freeze-stop bit is set.

Register map (word addresses): 0 control, 1 precision divider, 2 counter, 3 channel flags, 4 wrap flag (bit 0), 8+i data register of channel i. Control bits: [0] count enable, [1] fast-clear mode, [2] freeze-stop, [3] precision prescaler, [6:4] legacy divider select.

Top module: `tmr_flag_ctl`

## Requirements
- R1: After reset, the control, divider, counter, flag and channel data registers all read zero, and the counter does not advance.
- R2: While control bit 0 is set and the block is not frozen, the counter adds one at the end of each prescaler period of D enabled cycles, counted from the most recent counter load.
- R3: With control bit 3 clear, D is 2^N, where N is control bits [6:4], giving D from 1 to 128.
- R4: With control bit 3 set, D is P+1, where P is the 8-bit value in the divider register at address 1.
- R5: With control bit 2 set and freeze_i high, the counter and prescaler hold their values. With control bit 2 clear, freeze_i has no effect.
- R6: When the counter advances from 0xFFFF, it wraps to 0x0000 and sets the wrap flag. The wrap flag is visible at address 4 bit 0 and on ovf_o.
- R7: A one-cycle pulse on ch_evt_i[i] sets channel flag i. The channel flags are visible at address 3 and on ch_flag_o.
- R8: With control bit 1 clear, writing a one to a flag bit at address 3 or 4 clears that flag, and writing a zero leaves it. Accesses to data or counter registers clear no flag.
- R9: With control bit 1 set, a read or write of address 8+i clears channel flag i, and a read or write of address 2 clears the wrap flag.
- R10: With control bit 1 set, writing ones to address 3 or 4 leaves every flag unchanged.
- R11: When a flag's set event and a clear of that flag fall in the same cycle, the flag ends up set.
- R12: A write to address 2 loads the counter with the write data and restarts the prescaler. That cycle adds no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| freeze_i | input | 1 | Freeze request from a debug controller |
| ch_evt_i | input | 8 | One-cycle event pulse per channel |
| cnt_o | output | 16 | Current counter value |
| ch_flag_o | output | 8 | Channel flags |
| ovf_o | output | 1 | Counter-wrap flag |

## Verification
The prescaler is run with a table of settings: legacy selects of 1, 2, 4, 8 and 128, and precision values of 1, 3 and 10. Each is given a run length that is not a multiple of the divider, so the expected count separates truncation, an off-by-one period and a swapped mode bit. Flag clearing is driven with the same accesses in both modes: a flag write of ones, a data-register read, a data-register write and a counter read. The results show whether each access type clears or spares a flag under the selected method. Freeze is applied with the stop bit both set and clear. A set event that coincides with a clear separates set-priority from clear-priority. A counter load made mid-run and a wrap from 0xFFFF cover the load and overflow edges.

// File: rtl/tmr_flag_pkg.sv
`timescale 1ns/1ps
package tmr_flag_pkg;
  localparam int ADDR_W   = 5;
  localparam int CNT_W    = 16;
  localparam int PRE_W    = 8;
  localparam int NCH      = 8;
  localparam int CTRL_W   = 7;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 5'd1;
  localparam logic [ADDR_W-1:0] A_CNT   = 5'd2;
  localparam logic [ADDR_W-1:0] A_CHFLG = 5'd3;
  localparam logic [ADDR_W-1:0] A_WRAP  = 5'd4;
  localparam int                A_CHBASE = 8;

  localparam int B_EN   = 0;
  localparam int B_FAST = 1;
  localparam int B_FSTP = 2;
  localparam int B_PREC = 3;
  localparam int B_SEL  = 4;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] lim_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q, div_d;
  logic             div_en;

  always_comb begin
    tick_o = run_i && !restart_i && (div_q >= lim_i);
    div_en = run_i || restart_i;
    if (restart_i || tick_o) div_d = '0;
    else                     div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> $stable(div_q)); // R5
  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (div_q == '0)); // R12
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = tick_i || load_i;
    wrap_o = tick_i && !load_i && (cnt_q == CNT_MAX);
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i))); // R12
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt_q)); // R5
  AST_CNT_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0)); // R6
endmodule

// File: rtl/tmr_flag_bank.sv
`timescale 1ns/1ps
module tmr_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, flag_d, flag_en;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flag_en[i] = set_i[i] || clr_i[i];
      flag_d[i]  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i))); // R11
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((flag_q & $past(clr_i & ~set_i)) == '0)); // R9
  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(set_i)) == '0)); // R7
endmodule

// File: rtl/tmr_flag_ctl.sv
`timescale 1ns/1ps
module tmr_flag_ctl
  import tmr_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              freeze_i,
  input  logic [NCH-1:0]    ch_evt_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NCH-1:0]    ch_flag_o,
  output logic              ovf_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic           any_acc;
  logic           hit_ctrl, hit_div, hit_cnt, hit_chflg, hit_wrap;
  logic [NCH-1:0] hit_ch;

  always_comb begin
    any_acc   = bus_rd || bus_wr;
    hit_ctrl  = (bus_addr == A_CTRL);
    hit_div   = (bus_addr == A_DIV);
    hit_cnt   = (bus_addr == A_CNT);
    hit_chflg = (bus_addr == A_CHFLG);
    hit_wrap  = (bus_addr == A_WRAP);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign hit_ch[i] = (bus_addr == ADDR_W'(A_CHBASE + i));
  end

  // control and divider registers
  logic [CTRL_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  div_q;
  logic              ctrl_we, div_we;

  assign ctrl_we = bus_wr && hit_ctrl;
  assign div_we  = bus_wr && hit_div;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  div_q <= '0;
    else if (div_we) div_q <= bus_wdata[PRE_W-1:0];
  end

  logic       fast_clr, run;
  logic [2:0] sel;
  logic [PRE_W-1:0] lim;

  always_comb begin
    fast_clr = ctrl_q[B_FAST];
    sel      = ctrl_q[B_SEL +: 3];
    run      = ctrl_q[B_EN] && !(freeze_i && ctrl_q[B_FSTP]);
    if (ctrl_q[B_PREC]) lim = div_q;
    else                lim = ~({PRE_W{1'b1}} << sel);
  end

  // prescaler and counter
  logic             tick, cnt_load, wrap;
  logic [CNT_W-1:0] cnt;

  assign cnt_load = bus_wr && hit_cnt;

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run_i    (run),
    .restart_i(cnt_load),
    .lim_i    (lim),
    .tick_o   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick),
    .load_i    (cnt_load),
    .load_val_i(bus_wdata),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  // channel data registers
  logic [CNT_W-1:0] ch_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_chreg
    logic ch_we;
    assign ch_we = bus_wr && hit_ch[i];
    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) ch_q[i] <= '0;
      else if (ch_we) ch_q[i] <= bus_wdata;
    end
  end

  // flag clear selection: the two methods never act together
  logic [NCH-1:0] ch_clr, ch_flags;
  logic [0:0]     wrap_clr, wrap_flag;

  always_comb begin
    if (fast_clr) begin
      ch_clr      = any_acc ? hit_ch : '0;
      wrap_clr[0] = any_acc && hit_cnt;
    end else begin
      ch_clr      = (bus_wr && hit_chflg) ? bus_wdata[NCH-1:0] : '0;
      wrap_clr[0] = bus_wr && hit_wrap && bus_wdata[0];
    end
  end

  tmr_flag_bank #(.N(NCH)) u_chflg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (ch_evt_i),
    .clr_i (ch_clr),
    .flag_o(ch_flags)
  );

  tmr_flag_bank #(.N(1)) u_wrapflg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set_i (wrap),
    .clr_i (wrap_clr),
    .flag_o(wrap_flag)
  );

  // read data
  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)  bus_rdata = CNT_W'(ctrl_q);
    if (hit_div)   bus_rdata = CNT_W'(div_q);
    if (hit_cnt)   bus_rdata = cnt;
    if (hit_chflg) bus_rdata = CNT_W'(ch_flags);
    if (hit_wrap)  bus_rdata = CNT_W'(wrap_flag);
    for (int i = 0; i < NCH; i++) begin
      if (hit_ch[i]) bus_rdata = ch_q[i];
    end
  end

  assign cnt_o     = cnt;
  assign ch_flag_o = ch_flags;
  assign ovf_o     = wrap_flag[0];

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    wrap |=> ovf_o); // R6
  AST_FAST_W1C_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fast_clr && bus_wr && hit_wrap && !wrap) |=> (ovf_o == $past(ovf_o))); // R10
  AST_FAST_CH_W1C_IGNORED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fast_clr && bus_wr && hit_chflg) |=> ((ch_flag_o & ~$past(ch_evt_i)) == ($past(ch_flag_o) & ~$past(ch_evt_i)))); // R10
  AST_NORMAL_ACCESS_SPARES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fast_clr && any_acc && (|hit_ch)) |=> ((ch_flag_o & $past(ch_flag_o)) == $past(ch_flag_o))); // R8
endmodule

// File: tb/tmr_flag_ctl_tb.sv
`timescale 1ns/1ps
module tmr_flag_ctl_tb;
  typedef struct packed {
    logic        prec;
    logic [7:0]  div;
    logic [15:0] run_len;
    logic [15:0] exp_cnt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,  16'd9,   16'd10},
    '{1'b0, 8'd1,  16'd9,   16'd5},
    '{1'b0, 8'd3,  16'd20,  16'd2},
    '{1'b0, 8'd7,  16'd300, 16'd2},
    '{1'b0, 8'd2,  16'd2,   16'd0},
    '{1'b1, 8'd0,  16'd4,   16'd5},
    '{1'b1, 8'd2,  16'd10,  16'd3},
    '{1'b1, 8'd9,  16'd29,  16'd3}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_rd, bus_wr;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        freeze_i;
  logic [7:0]  ch_evt_i;
  logic [15:0] cnt_o;
  logic [7:0]  ch_flag_o;
  logic        ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tmr_flag_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .freeze_i(freeze_i), .ch_evt_i(ch_evt_i), .cnt_o(cnt_o),
    .ch_flag_o(ch_flag_o), .ovf_o(ovf_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; freeze_i = 1'b0; ch_evt_i = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd(5'd0, d);  check("R1 ctrl", d, 16'h0);
    rd(5'd1, d);  check("R1 div", d, 16'h0);
    rd(5'd2, d);  check("R1 cnt", d, 16'h0);
    rd(5'd3, d);  check("R1 chflg", d, 16'h0);
    rd(5'd4, d);  check("R1 wrap", d, 16'h0);
    rd(5'd12, d); check("R1 chreg", d, 16'h0);
    idle(5);
    check("R1 idle cnt", cnt_o, 16'h0);

    // R2 R3 R4 prescaler table
    foreach (VECS[v]) begin
      wr(5'd0, 16'h0);
      if (VECS[v].prec) wr(5'd1, {8'h0, VECS[v].div});
      wr(5'd2, 16'h0);
      wr(5'd0, {9'h0, VECS[v].div[2:0], VECS[v].prec, 3'b001});
      idle(int'(VECS[v].run_len));
      wr(5'd0, 16'h0);
      rd(5'd2, d);
      check(VECS[v].prec ? "R4 precision divide" : "R3 legacy divide R2", d, VECS[v].exp_cnt);
    end

    // R5 freeze with stop bit set
    freeze_i = 1'b1;
    wr(5'd2, 16'h0);
    wr(5'd0, 16'h0005);
    idle(5);
    wr(5'd0, 16'h0);
    check("R5 frozen", cnt_o, 16'h0);
    // R5 freeze ignored with stop bit clear
    wr(5'd2, 16'h0);
    wr(5'd0, 16'h0001);
    idle(4);
    wr(5'd0, 16'h0);
    check("R5 stop bit clear", cnt_o, 16'd5);
    freeze_i = 1'b0;

    // R6 wrap in normal mode
    wr(5'd2, 16'hFFFE);
    wr(5'd0, 16'h0001);
    idle(1);
    wr(5'd0, 16'h0);
    check("R6 wrap cnt", cnt_o, 16'h0);
    check("R6 wrap flag", {15'h0, ovf_o}, 16'h1);
    rd(5'd4, d); check("R6 wrap reg", d, 16'h1);
    // R8 write zero keeps, write one clears
    wr(5'd4, 16'h0);
    check("R8 write zero", {15'h0, ovf_o}, 16'h1);
    wr(5'd4, 16'h1);
    check("R8 write one", {15'h0, ovf_o}, 16'h0);

    // R7 channel events
    ch_evt_i = 8'hA5;
    @(negedge clk);
    ch_evt_i = 8'h00;
    check("R7 set", {8'h0, ch_flag_o}, 16'h00A5);
    rd(5'd3, d); check("R7 reg", d, 16'h00A5);
    rd(5'd8, d);
    check("R8 access no clear", {8'h0, ch_flag_o}, 16'h00A5);
    wr(5'd3, 16'h0005);
    check("R8 w1c", {8'h0, ch_flag_o}, 16'h00A0);

    // R10 fast mode ignores write-one
    wr(5'd0, 16'h0002);
    wr(5'd3, 16'h00FF);
    check("R10 chflg w1c ignored", {8'h0, ch_flag_o}, 16'h00A0);
    // R9 read and write of channel data clear
    rd(5'd13, d);
    check("R9 read clears", {8'h0, ch_flag_o}, 16'h0080);
    wr(5'd15, 16'h1234);
    check("R9 write clears", {8'h0, ch_flag_o}, 16'h0000);
    rd(5'd15, d); check("R9 data kept", d, 16'h1234);

    // R9 R10 wrap flag in fast mode
    wr(5'd2, 16'hFFFF);
    wr(5'd0, 16'h0003);
    wr(5'd0, 16'h0002);
    check("R6 fast wrap", {15'h0, ovf_o}, 16'h1);
    wr(5'd4, 16'h0001);
    check("R10 wrap w1c ignored", {15'h0, ovf_o}, 16'h1);
    rd(5'd2, d);
    check("R9 cnt read clears", {15'h0, ovf_o}, 16'h0);

    // R11 set beats clear in the same cycle
    wr(5'd0, 16'h0);
    bus_addr = 5'd3; bus_wdata = 16'h0008; bus_wr = 1'b1; ch_evt_i = 8'h08;
    @(negedge clk);
    bus_wr = 1'b0; ch_evt_i = 8'h00;
    check("R11 set wins", {8'h0, ch_flag_o}, 16'h0008);
    wr(5'd3, 16'h0008);
    check("R8 clear after", {8'h0, ch_flag_o}, 16'h0);

    // R12 load while running
    wr(5'd0, 16'h0001);
    idle(3);
    wr(5'd2, 16'h1000);
    check("R12 load no count", cnt_o, 16'h1000);
    wr(5'd0, 16'h0);
    check("R12 count resumes", cnt_o, 16'h1001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule